// File: doc/BRIEF.md
# Compare-Split Merge Unit

This block performs the exchange step used when two neighbouring workers each own a sorted run of keys and must redistribute them. Each worker puts K keys into the unit. The "low" worker keeps the smaller keys and the "high" worker keeps the larger keys. Software or a neighbouring engine first writes the two ascending blocks into the unit's input banks through a simple indexed write port. It then pulses `start`.

The unit runs two merges at the same time, one key per cycle. The forward merge walks both blocks from their smallest end and fills the low result bank with the K smallest keys of the union. The backward merge walks both blocks from their largest end and fills the high result bank with the K largest keys. Both results end up in ascending order. After exactly K steps both halves are complete, and a one-cycle `done` pulse is raised. Either result bank can then be read through a shared index.

Keys are unsigned. When two keys are equal, the forward merge takes the low block's key first and the backward merge takes the high block's key first. Because of this rule, the union is split exactly and no key is lost or doubled. An internal two-flop stage releases the asynchronous active-low reset synchronously.

Top module: `cs_merge_unit`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are 0.
- R2: When `load_en` is 1 at a clock edge, `load_key` is written to entry `load_idx` of the input block chosen by `load_side`: 0 selects the low block and 1 selects the high block. Entry 0 holds the smallest key.
- R3: A `start` sampled while idle makes `busy` read 1 from the next cycle. Exactly K clock edges after the start edge, `busy` drops and `done` is 1 for one cycle only.
- R4: After `done`, reading `rd_lo_key` at index i (0..K-1) returns the i-th smallest key of the combined 2K keys.
- R5: After `done`, reading `rd_hi_key` at index i returns the (K+i)-th smallest key of the combined 2K keys, so the high result is the K largest keys in ascending order.
- R6: With equal keys inside or across the blocks, the two results together hold exactly the multiset of the 2K input keys.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. The running merge keeps its step count, and `done` still arrives K edges after the original start.
- R8: With K = 1 the unit acts as a compare-exchange. The low result is the minimum of the two keys, the high result is the maximum, and `done` follows one edge after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one key into an input block |
| load_side | input | 1 | Block select: 0 low, 1 high |
| load_idx | input | IW | Entry index for the write |
| load_key | input | W | Key value to write |
| start | input | 1 | Begin a merge (ignored while busy) |
| busy | output | 1 | Merge in progress |
| done | output | 1 | One-cycle pulse when both halves are complete |
| rd_idx | input | IW | Read index into both result banks |
| rd_lo_key | output | W | Low result entry at `rd_idx` |
| rd_hi_key | output | W | High result entry at `rd_idx` |

## Verification
Several properties are checked on every cycle of a run:
- The keys written to the low bank never decrease and the keys written to the high bank never increase.
- The number of keys taken by each merge always equals the step count.
- The last low key never exceeds the last high key.
- `done` lasts one cycle, and a start that arrives while busy does not disturb the step count.

Only the bench scenarios can show that the banks end up holding the correct ranks of the union. These scenarios cover interleaved blocks, fully disjoint blocks in both orders, all-equal keys, duplicates at the extreme values, and a separate K = 1 instance.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_RUN  = 1'b1
  } cs_state_e;
endpackage

// File: rtl/cs_key_bank.sv
module cs_key_bank #(
  parameter int W   = 16,
  parameter int K   = 8,
  parameter int NRD = 1,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_key,
  input  logic [IW-1:0] rd_idx [NRD],
  output logic [W-1:0]  rd_key [NRD]
);
  logic [W-1:0] mem_q [K];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_key;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_key[r] = mem_q[rd_idx[r]];
  end
endmodule

// File: rtl/cs_pick.sv
module cs_pick #(
  parameter int W        = 16,
  parameter bit PICK_MAX = 1'b0
) (
  input  logic [W-1:0] a_key,
  input  logic [W-1:0] b_key,
  output logic         take_a,
  output logic [W-1:0] out_key
);
  if (PICK_MAX) begin : g_max
    // larger key wins; on a tie the high-side block (b) goes first
    assign take_a = (a_key > b_key);
  end else begin : g_min
    // smaller key wins; on a tie the low-side block (a) goes first
    assign take_a = (a_key <= b_key);
  end

  assign out_key = take_a ? a_key : b_key;
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int K   = 8,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          take_lo_a,
  input  logic          take_hi_a,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [IW-1:0] step,
  output logic [IW-1:0] fa,
  output logic [IW-1:0] fb,
  output logic [IW-1:0] ba,
  output logic [IW-1:0] bb
);
  localparam logic [IW-1:0] LAST = IW'(K - 1);

  cs_state_e     state_q, state_d;
  logic          done_q, done_d;
  logic [IW-1:0] step_q, step_d;
  logic [IW-1:0] fa_q, fa_d, fb_q, fb_d;
  logic [IW-1:0] ba_q, ba_d, bb_q, bb_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    step_d  = step_q;
    fa_d    = fa_q;
    fb_d    = fb_q;
    ba_d    = ba_q;
    bb_d    = bb_q;
    unique case (state_q)
      CS_IDLE: begin
        if (start) begin
          state_d = CS_RUN;
          step_d  = '0;
          fa_d    = '0;
          fb_d    = '0;
          ba_d    = LAST;
          bb_d    = LAST;
        end
      end
      CS_RUN: begin
        if (take_lo_a) fa_d = fa_q + 1'b1;
        else           fb_d = fb_q + 1'b1;
        if (take_hi_a) ba_d = ba_q - 1'b1;
        else           bb_d = bb_q - 1'b1;
        step_d = step_q + 1'b1;
        if (step_q == LAST) begin
          state_d = CS_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      done_q  <= 1'b0;
      step_q  <= '0;
      fa_q    <= '0;
      fb_q    <= '0;
      ba_q    <= '0;
      bb_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      step_q  <= step_d;
      fa_q    <= fa_d;
      fb_q    <= fb_d;
      ba_q    <= ba_d;
      bb_q    <= bb_d;
    end
  end

  assign busy  = (state_q == CS_RUN);
  assign done  = done_q;
  assign wr_en = busy;
  assign step  = step_q;
  assign fa    = fa_q;
  assign fb    = fb_q;
  assign ba    = ba_q;
  assign bb    = bb_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != LAST) |=> (busy && step == IW'($past(step) + 1'b1))); // R7
  AST_FWD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (IW'(fa + fb) == step)); // R4
  AST_BWD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (IW'((LAST - ba) + (LAST - bb)) == step)); // R5
endmodule

// File: rtl/cs_merge_unit.sv
module cs_merge_unit #(
  parameter int W   = 16,
  parameter int K   = 8,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          load_side,
  input  logic [IW-1:0] load_idx,
  input  logic [W-1:0]  load_key,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_lo_key,
  output logic [W-1:0]  rd_hi_key
);
  localparam logic [IW-1:0] LAST = IW'(K - 1);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic          wr_en;
  logic [IW-1:0] step, fa, fb, ba, bb;
  logic          take_lo_a, take_hi_a;
  logic [W-1:0]  lo_key, hi_key;

  // input blocks: read port 0 follows the forward merge, port 1 the backward
  logic [IW-1:0] a_rd_idx [2];
  logic [IW-1:0] b_rd_idx [2];
  logic [W-1:0]  a_rd_key [2];
  logic [W-1:0]  b_rd_key [2];
  assign a_rd_idx[0] = fa;
  assign a_rd_idx[1] = ba;
  assign b_rd_idx[0] = fb;
  assign b_rd_idx[1] = bb;

  cs_key_bank #(.W(W), .K(K), .NRD(2)) u_blk_lo (
    .clk   (clk),
    .wr_en (load_en && !load_side),
    .wr_idx(load_idx),
    .wr_key(load_key),
    .rd_idx(a_rd_idx),
    .rd_key(a_rd_key)
  );

  cs_key_bank #(.W(W), .K(K), .NRD(2)) u_blk_hi (
    .clk   (clk),
    .wr_en (load_en && load_side),
    .wr_idx(load_idx),
    .wr_key(load_key),
    .rd_idx(b_rd_idx),
    .rd_key(b_rd_key)
  );

  cs_pick #(.W(W), .PICK_MAX(1'b0)) u_pick_fwd (
    .a_key  (a_rd_key[0]),
    .b_key  (b_rd_key[0]),
    .take_a (take_lo_a),
    .out_key(lo_key)
  );

  cs_pick #(.W(W), .PICK_MAX(1'b1)) u_pick_bwd (
    .a_key  (a_rd_key[1]),
    .b_key  (b_rd_key[1]),
    .take_a (take_hi_a),
    .out_key(hi_key)
  );

  cs_ctrl #(.K(K)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start    (start),
    .take_lo_a(take_lo_a),
    .take_hi_a(take_hi_a),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .step     (step),
    .fa       (fa),
    .fb       (fb),
    .ba       (ba),
    .bb       (bb)
  );

  // result banks: low fills from entry 0 upward, high from entry K-1 downward
  logic [IW-1:0] res_rd_idx [1];
  logic [W-1:0]  res_lo_key [1];
  logic [W-1:0]  res_hi_key [1];
  assign res_rd_idx[0] = rd_idx;

  cs_key_bank #(.W(W), .K(K), .NRD(1)) u_res_lo (
    .clk   (clk),
    .wr_en (wr_en),
    .wr_idx(step),
    .wr_key(lo_key),
    .rd_idx(res_rd_idx),
    .rd_key(res_lo_key)
  );

  cs_key_bank #(.W(W), .K(K), .NRD(1)) u_res_hi (
    .clk   (clk),
    .wr_en (wr_en),
    .wr_idx(IW'(LAST - step)),
    .wr_key(hi_key),
    .rd_idx(res_rd_idx),
    .rd_key(res_hi_key)
  );

  assign rd_lo_key = res_lo_key[0];
  assign rd_hi_key = res_hi_key[0];

  AST_LOW_ASCENDING: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_en && step != '0) |-> (lo_key >= $past(lo_key))); // R4
  AST_HIGH_DESCENDING: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_en && step != '0) |-> (hi_key <= $past(hi_key))); // R5
  AST_HALVES_SPLIT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_en && step == LAST) |-> (lo_key <= hi_key)); // R6
endmodule

// File: tb/tb_cs_merge_unit.sv
module tb_cs_merge_unit;
  localparam int  W       = 16;
  localparam int  K       = 8;
  localparam int  IW      = 3;
  localparam time CLK_PER = 10ns;
  localparam int  NCASE   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  logic          load_en = 1'b0, load_side = 1'b0, start = 1'b0;
  logic [IW-1:0] load_idx = '0, rd_idx = '0;
  logic [W-1:0]  load_key = '0;
  logic          busy, done;
  logic [W-1:0]  rd_lo_key, rd_hi_key;

  cs_merge_unit #(.W(W), .K(K)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_side(load_side),
    .load_idx(load_idx), .load_key(load_key), .start(start), .busy(busy),
    .done(done), .rd_idx(rd_idx), .rd_lo_key(rd_lo_key), .rd_hi_key(rd_hi_key)
  );

  logic         k1_load_en = 1'b0, k1_load_side = 1'b0, k1_start = 1'b0;
  logic [0:0]   k1_load_idx = '0, k1_rd_idx = '0;
  logic [W-1:0] k1_load_key = '0;
  logic         k1_busy, k1_done;
  logic [W-1:0] k1_lo, k1_hi;

  cs_merge_unit #(.W(W), .K(1)) dut_k1 (
    .clk(clk), .rst_n(rst_n), .load_en(k1_load_en), .load_side(k1_load_side),
    .load_idx(k1_load_idx), .load_key(k1_load_key), .start(k1_start), .busy(k1_busy),
    .done(k1_done), .rd_idx(k1_rd_idx), .rd_lo_key(k1_lo), .rd_hi_key(k1_hi)
  );

  // stimulus table: entry i of a block sits at bits [i*W +: W]
  localparam logic [K*W-1:0] LO_TAB [NCASE] = '{
    128'h000F_000D_000B_0009_0007_0005_0003_0001,
    128'h0017_0016_0015_0014_0013_0012_0011_0010,
    128'h0027_0026_0025_0024_0023_0022_0021_0020,
    128'h0555_0555_0555_0555_0555_0555_0555_0555,
    128'hFFFF_FFFF_FFFF_FFFF_0002_0002_0000_0000
  };
  localparam logic [K*W-1:0] HI_TAB [NCASE] = '{
    128'h0010_000E_000C_000A_0008_0006_0004_0002,
    128'h0027_0026_0025_0024_0023_0022_0021_0020,
    128'h0017_0016_0015_0014_0013_0012_0011_0010,
    128'h0555_0555_0555_0555_0555_0555_0555_0555,
    128'hFFFF_FFFF_0005_0004_0003_0002_0001_0000
  };
  localparam bit TIE_TAB [NCASE] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R2: write both blocks through the load port
  task automatic load_blocks(input logic [K*W-1:0] lo, input logic [K*W-1:0] hi);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < K; i++) begin
        @(negedge clk);
        load_en   = 1'b1;
        load_side = s[0];
        load_idx  = IW'(i);
        load_key  = (s == 0) ? lo[i*W +: W] : hi[i*W +: W];
      end
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // R3 / R7: start timing, optional second start while busy
  task automatic run_merge(input bit inject);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3", "busy after start", 32'(busy), 32'd1);
    for (int c = 1; c < K; c++) begin
      if (inject && c == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (c == K - 1 || (inject && c == 3))
        chk(done == 1'b0 && busy == 1'b1, inject ? "R7" : "R3", "still running",
            32'({busy, done}), 32'b10);
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, inject ? "R7" : "R3", "done after K edges",
        32'({busy, done}), 32'b01);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R3", "done lasts one cycle",
        32'({busy, done}), 32'b00);
  endtask

  task automatic check_case(input int ci);
    logic [W-1:0] u [2*K];
    logic [W-1:0] t;
    string rq_lo, rq_hi;
    for (int i = 0; i < K; i++) begin
      u[i]     = LO_TAB[ci][i*W +: W];
      u[K + i] = HI_TAB[ci][i*W +: W];
    end
    for (int i = 1; i < 2 * K; i++) begin
      for (int j = i; j > 0 && u[j-1] > u[j]; j--) begin
        t = u[j]; u[j] = u[j-1]; u[j-1] = t;
      end
    end
    rq_lo = TIE_TAB[ci] ? "R2 R4 R6" : "R2 R4";
    rq_hi = TIE_TAB[ci] ? "R2 R5 R6" : "R2 R5";
    for (int i = 0; i < K; i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      #1;
      chk(rd_lo_key == u[i], rq_lo, $sformatf("case %0d low[%0d]", ci, i),
          32'(rd_lo_key), 32'(u[i]));
      chk(rd_hi_key == u[K + i], rq_hi, $sformatf("case %0d high[%0d]", ci, i),
          32'(rd_hi_key), 32'(u[K + i]));
    end
  endtask

  // R8: single-key compare-exchange on the K=1 instance
  task automatic k1_case(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] mn, mx;
    mn = (a < b) ? a : b;
    mx = (a < b) ? b : a;
    @(negedge clk);
    k1_load_en = 1'b1; k1_load_side = 1'b0; k1_load_key = a;
    @(negedge clk);
    k1_load_side = 1'b1; k1_load_key = b;
    @(negedge clk);
    k1_load_en = 1'b0; k1_start = 1'b1;
    @(negedge clk);
    k1_start = 1'b0;
    chk(k1_busy == 1'b1 && k1_done == 1'b0, "R8", "K1 running",
        32'({k1_busy, k1_done}), 32'b10);
    @(negedge clk);
    chk(k1_done == 1'b1 && k1_busy == 1'b0, "R8", "K1 done", 32'({k1_busy, k1_done}), 32'b01);
    chk(k1_lo == mn, "R8", "K1 min", 32'(k1_lo), 32'(mn));
    chk(k1_hi == mx, "R8", "K1 max", 32'(k1_hi), 32'(mx));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    #3;
    chk(busy == 1'b0 && done == 1'b0, "R1", "outputs in reset", 32'({busy, done}), 32'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "outputs after reset", 32'({busy, done}), 32'b00);

    for (int ci = 0; ci < NCASE; ci++) begin
      load_blocks(LO_TAB[ci], HI_TAB[ci]);
      run_merge(ci == 2);
      check_case(ci);
    end

    k1_case(16'h0005, 16'h0003);
    k1_case(16'h0007, 16'h0007);
    k1_case(16'h0000, 16'hFFFF);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule